// File: doc/BRIEF.md
# Shift and Rotate Unit

A combinational barrel shifter for a processor ALU datapath. The caller presents one data operand and two possible shift amounts: a narrow immediate amount field and a full-width register value. The caller also presents an operation code. In the same cycle the unit returns the operand shifted logically left or right, shifted arithmetically right, or rotated left or right. The operation code picks which amount source applies. Register-sourced amounts use only the low bits of the register value.

Inside, the unit is a logarithmic chain of conditional stages, one for each bit of the shift amount. Left-direction shifts are done by reversing the bit order around a right-direction core. A left rotate by n is done as a right rotate by (width - n) mod width. The unit has no clock and no state. The data width is a parameter and must be a power of two.

Top module: `shr_unit`

## Requirements
- R1: The effective shift amount ranges from 0 to 31 for the default 32-bit width. An effective amount of 0 returns the operand unchanged for every operation code.
- R2: Operation code 3'b000 (immediate logical left) shifts left by the immediate amount and fills the vacated low-order bits with zeroes.
- R3: Operation code 3'b001 (immediate logical right) shifts right by the immediate amount and fills the vacated high-order bits with zeroes.
- R4: Operation code 3'b010 (immediate arithmetic right) shifts right by the immediate amount and fills the vacated high-order bits with copies of operand bit 31.
- R5: Operation codes 3'b100, 3'b101 and 3'b110 behave as logical left, logical right and arithmetic right. Their amount is the 5 least significant bits of the register amount input. The immediate amount and the upper register bits have no effect.
- R6: Operation code 3'b011 rotates left by the immediate amount. Bits leaving the top re-enter at the bottom. For example, 0xD2345678 rotated by 4 gives 0x2345678D.
- R7: Operation code 3'b111 rotates right by the immediate amount. Its result equals a left rotate by (32 - n) mod 32.
- R8: The result depends only on the present inputs, with no clocked state. A new input set is reflected at the output within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | DATA_W (32) | Data operand to shift or rotate |
| imm_amt_i | input | log2(DATA_W) (5) | Immediate shift-amount field |
| reg_amt_i | input | DATA_W (32) | Register value; its low bits give the variable amount |
| op_i | input | 3 | Operation code (see R2 to R7) |
| result_o | output | DATA_W (32) | Shifted or rotated result |

## Verification
The bench builds the unit with its default 32-bit width, so every one of the 32 amounts and both rotate directions can be compared against a bench-side reference model. This width makes the sign fill of the arithmetic shift reach all 31 vacated bits. It also makes the rotate amount conversion wrap at zero. Directed vectors hold the operand and register fixed while they vary the immediate field and the upper register bits, which tests that those inputs are ignored.

// File: rtl/shr_pkg.sv
package shr_pkg;

   typedef enum logic [2:0] {
      OP_SLL_IMM = 3'b000,
      OP_SRL_IMM = 3'b001,
      OP_SRA_IMM = 3'b010,
      OP_ROL_IMM = 3'b011,
      OP_SLL_REG = 3'b100,
      OP_SRL_REG = 3'b101,
      OP_SRA_REG = 3'b110,
      OP_ROR_IMM = 3'b111
   } shr_op_e;

   function automatic logic op_is_left(input shr_op_e op);
      return (op == OP_SLL_IMM) || (op == OP_SLL_REG);
   endfunction

   function automatic logic op_is_arith(input shr_op_e op);
      return (op == OP_SRA_IMM) || (op == OP_SRA_REG);
   endfunction

   function automatic logic op_is_rot(input shr_op_e op);
      return (op == OP_ROL_IMM) || (op == OP_ROR_IMM);
   endfunction

   function automatic logic op_uses_reg(input shr_op_e op);
      return (op == OP_SLL_REG) || (op == OP_SRL_REG) || (op == OP_SRA_REG);
   endfunction

endpackage

// File: rtl/shr_amount_sel.sv
module shr_amount_sel
   import shr_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  shr_op_e           op_i,
   input  logic [AMT_W-1:0]  imm_amt_i,
   input  logic [DATA_W-1:0] reg_amt_i,
   output logic [AMT_W-1:0]  eff_amt_o,
   output logic [AMT_W-1:0]  right_amt_o,
   output logic              reverse_o,
   output logic              wrap_o,
   output logic              arith_o
);

   always_comb begin
      eff_amt_o = op_uses_reg(op_i) ? reg_amt_i[AMT_W-1:0] : imm_amt_i;
      // left rotate by n == right rotate by (W - n) mod W
      right_amt_o = (op_i == OP_ROL_IMM) ? AMT_W'(-eff_amt_o) : eff_amt_o;
      reverse_o   = op_is_left(op_i);
      wrap_o      = op_is_rot(op_i);
      arith_o     = op_is_arith(op_i);
   end

   always_comb begin
      if (op_i == OP_ROL_IMM && eff_amt_o == '0)
         assert_rol_zero_R1: assert (right_amt_o == '0)
            else $error("left rotate by zero must map to right rotate by zero");
      if (op_uses_reg(op_i))
         assert_no_wrap_on_var_R5: assert (!wrap_o)
            else $error("variable shift must not wrap");
   end

endmodule

// File: rtl/shr_stage.sv
module shr_stage #(
   parameter int DATA_W = 32,
   parameter int STEP   = 1
) (
   input  logic [DATA_W-1:0] d_i,
   input  logic              en_i,
   input  logic              wrap_i,
   input  logic              fill_i,
   output logic [DATA_W-1:0] q_o
);

   always_comb begin
      if (!en_i)
         q_o = d_i;
      else if (wrap_i)
         q_o = {d_i[STEP-1:0], d_i[DATA_W-1:STEP]};
      else
         q_o = {{STEP{fill_i}}, d_i[DATA_W-1:STEP]};
   end

endmodule

// File: rtl/shr_unit.sv
module shr_unit
   import shr_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [AMT_W-1:0]  imm_amt_i,
   input  logic [DATA_W-1:0] reg_amt_i,
   input  logic [2:0]        op_i,
   output logic [DATA_W-1:0] result_o
);

   generate
      if (DATA_W < 2 || (1 << AMT_W) != DATA_W) begin : g_bad_width
         $error("shr_unit: DATA_W must be a power of two and at least 2");
      end
   endgenerate

   shr_op_e          op;
   logic [AMT_W-1:0] eff_amt, right_amt;
   logic             reverse, wrap, arith, fill;
   logic [DATA_W-1:0] core_in, core_out;
   logic [DATA_W-1:0] stg [0:AMT_W];

   assign op = shr_op_e'(op_i);

   shr_amount_sel #(.DATA_W(DATA_W)) u_amt (
      .op_i        (op),
      .imm_amt_i   (imm_amt_i),
      .reg_amt_i   (reg_amt_i),
      .eff_amt_o   (eff_amt),
      .right_amt_o (right_amt),
      .reverse_o   (reverse),
      .wrap_o      (wrap),
      .arith_o     (arith)
   );

   assign fill = arith & opnd_i[DATA_W-1];

   always_comb begin
      for (int b = 0; b < DATA_W; b++)
         core_in[b] = reverse ? opnd_i[DATA_W-1-b] : opnd_i[b];
   end

   assign stg[0] = core_in;

   generate
      for (genvar k = 0; k < AMT_W; k++) begin : g_stage
         shr_stage #(.DATA_W(DATA_W), .STEP(1 << k)) u_stage (
            .d_i    (stg[k]),
            .en_i   (right_amt[k]),
            .wrap_i (wrap),
            .fill_i (fill),
            .q_o    (stg[k+1])
         );
      end
   endgenerate

   assign core_out = stg[AMT_W];

   always_comb begin
      for (int b = 0; b < DATA_W; b++)
         result_o[b] = reverse ? core_out[DATA_W-1-b] : core_out[b];
   end

   // Checks on the settled result
   logic [DATA_W-1:0] lo_mask, hi_mask;
   always_comb begin
      lo_mask = ~({DATA_W{1'b1}} << eff_amt);
      hi_mask = ~({DATA_W{1'b1}} >> eff_amt);
      if (eff_amt == '0)
         assert_zero_amt_R1: assert (result_o == opnd_i)
            else $error("zero amount altered operand");
      if (op == OP_SLL_IMM || op == OP_SLL_REG)
         assert_left_zero_fill_R2: assert ((result_o & lo_mask) == '0)
            else $error("left shift fill not zero");
      if (op == OP_SRL_IMM || op == OP_SRL_REG)
         assert_right_zero_fill_R3: assert ((result_o & hi_mask) == '0)
            else $error("logical right fill not zero");
      if (op == OP_SRA_IMM || op == OP_SRA_REG)
         assert_sign_fill_R4: assert ((result_o & hi_mask) == (opnd_i[DATA_W-1] ? hi_mask : '0))
            else $error("arithmetic fill not sign");
      if (op == OP_ROL_IMM || op == OP_ROR_IMM)
         assert_rot_keeps_ones_R6: assert ($countones(result_o) == $countones(opnd_i))
            else $error("rotate lost bits");
   end

endmodule

// File: tb/shr_unit_bench.sv
module shr_unit_bench;

   logic        clk = 1'b0;
   logic [31:0] opnd, regv, result;
   logic [4:0]  imm;
   logic [2:0]  op;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   shr_unit u_shr_unit (
      .opnd_i    (opnd),
      .imm_amt_i (imm),
      .reg_amt_i (regv),
      .op_i      (op),
      .result_o  (result)
   );

   function automatic logic [31:0] ref_model(input logic [2:0] o, input logic [31:0] x,
                                             input logic [4:0] im, input logic [31:0] rv);
      int a;
      a = (o == 3'b100 || o == 3'b101 || o == 3'b110) ? int'(rv[4:0]) : int'(im);
      case (o)
         3'b000, 3'b100: return x << a;
         3'b001, 3'b101: return x >> a;
         3'b010, 3'b110: return 32'($signed(x) >>> a);
         3'b011:         return (a == 0) ? x : ((x << a) | (x >> (32 - a)));
         default:        return (a == 0) ? x : ((x >> a) | (x << (32 - a)));
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] o);
      case (o)
         3'b000: return "R2";
         3'b001: return "R3";
         3'b010: return "R4";
         3'b011: return "R6";
         3'b111: return "R7";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] exp);
      checks++;
      if (result !== exp) begin
         failures++;
         $display("FAIL %s op=%b opnd=%h imm=%0d reg=%h actual=%h expected=%h",
                  req, op, opnd, imm, regv, result, exp);
      end
   endtask

   task automatic apply(input logic [2:0] o, input logic [31:0] x,
                        input logic [4:0] im, input logic [31:0] rv);
      @(posedge clk);
      op = o; opnd = x; imm = im; regv = rv;
      #2;
   endtask

   initial begin
      logic [31:0] first;
      void'($urandom(32'h5EED_1234));
      op = 3'b000; opnd = '0; imm = '0; regv = '0;
      #2;
      check("R8", 32'h0);   // idle inputs give zero

      // R6 worked example
      apply(3'b011, 32'hD234_5678, 5'd4, 32'h0);
      check("R6", 32'h2345_678D);
      // R7 right rotate by 1 and its left-rotate equivalence
      apply(3'b111, 32'h0000_0001, 5'd1, 32'h0);
      check("R7", 32'h8000_0000);
      apply(3'b011, 32'h0000_0001, 5'd31, 32'h0);
      check("R7", 32'h8000_0000);
      // R1 zero amount on every op
      for (int o = 0; o < 8; o++) begin
         apply(3'(o), 32'hA5C3_0F96, 5'd0, 32'hFFFF_FFE0);
         check("R1", 32'hA5C3_0F96);
      end
      // R4 full sign fill, R2/R3 extreme amounts
      apply(3'b010, 32'h8000_0000, 5'd31, 32'h0);
      check("R4", 32'hFFFF_FFFF);
      apply(3'b010, 32'h7FFF_FFFF, 5'd31, 32'h0);
      check("R4", 32'h0000_0000);
      apply(3'b000, 32'hFFFF_FFFF, 5'd31, 32'h0);
      check("R2", 32'h8000_0000);
      apply(3'b001, 32'hFFFF_FFFF, 5'd31, 32'h0);
      check("R3", 32'h0000_0001);
      // R5: immediate and upper register bits ignored
      apply(3'b110, 32'hF000_0000, 5'd0, 32'h0000_0004);
      first = result;
      check("R5", 32'hFF00_0000);
      apply(3'b110, 32'hF000_0000, 5'd17, 32'hABCD_EF04);
      check("R5", first);
      apply(3'b100, 32'h0000_0003, 5'd31, 32'hFFFF_FFE2);
      check("R5", 32'h0000_000C);
      apply(3'b101, 32'h8000_0000, 5'd3, 32'h0000_001F);
      check("R5", 32'h0000_0001);

      // Random vectors across all ops
      for (int i = 0; i < 4000; i++) begin
         logic [2:0]  ro;
         logic [31:0] rx, rr;
         logic [4:0]  ri;
         ro = 3'($urandom); rx = $urandom; ri = 5'($urandom); rr = $urandom;
         apply(ro, rx, ri, rr);
         check(req_of(ro), ref_model(ro, rx, ri, rr));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R8 watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule